// File: doc/BRIEF.md
# Serial EEPROM Page-Write Slave

This block is the receive-and-commit half of a two-wire serial nonvolatile memory slave. A fast system clock oversamples the bus clock and data lines through two-flop synchronisers, finds START and STOP conditions, and shifts in bytes on the rising edges of the bus clock. A transfer opens with a slave address byte. That byte holds a fixed device-type code, one memory address bit that picks the upper or lower half of a 512-byte array, and the read/write select. A word address byte follows, then one or more data bytes. The slave pulls SDA low to acknowledge every byte it accepts.

Data bytes go into a 16-entry page buffer. The low four address bits step after each byte and wrap inside the page, while the page-select bits stay fixed. A STOP that follows at least one data byte starts a timed internal write. In that window the buffered bytes are copied into the behavioural memory array, the busy flag is high, and the slave ignores the bus completely. A registered read port on the array is exposed for the neighbouring read-transfer logic, and the bench uses the same port to observe stored data.

Top module: `eep_page_writer`

## Requirements
- R1: A byte write (one data byte followed by STOP) stores that byte at the 9-bit array address {A8, word address}.
- R2: The slave holds SDA low during the ninth bus clock after an accepted slave address byte, after the word address byte, and after every data byte.
- R3: The busy flag rises within a few system clocks of a STOP that follows at least one data byte. A STOP or START that comes earlier in a transfer abandons it, so no write starts and the array is unchanged.
- R4: While busy is high the slave acknowledges nothing, including its own address, and bytes sent during that time are never stored.
- R5: After each data byte the low four bits of the word address increment modulo 16. Word address bits 7:4 and A8 stay fixed, so a page write that starts near the end of a page wraps to that page's first byte.
- R6: When more than 16 data bytes arrive before STOP, the later bytes replace the ones buffered earlier at the same in-page position.
- R7: Slave address bit 0 selects the operation (1 = read, 0 = write). A byte with bit 0 set gets no acknowledge, and the slave stays silent until the next START.
- R8: Slave address bits 7:4 must equal 4'b1010, or the byte gets no acknowledge and the slave stays silent until the next START. Bit 1 supplies A8, and bits 3:2 are ignored.
- R9: Busy stays high for exactly TWR_CYCLES system clocks for every internal write.
- R10: SDA is driven only during acknowledge bit periods. The drive starts after a falling bus clock edge and is released at the next falling edge, so sda_oe is low whenever the bus clock is high during a data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |
| busy | output | 1 | High for the whole internal write time |
| rd_addr | input | 9 | Array read address for the neighbouring read logic |
| rd_data | output | 8 | Array data, one clock after rd_addr |

## Verification
Two functions can coincide: the internal write that follows a STOP, and the decoding of a new slave address from a master that does not wait. The bench provokes this by issuing a START, an address byte, a word address and a data byte right after the STOP, so that the whole sequence falls inside the busy window. The result is judged at the pins and in the array. Every acknowledge slot must see SDA released, the busy length must not change, and the earlier committed byte must remain in place while the byte sent during busy is nowhere stored.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_DATA,
    ST_SKIP,
    ST_BUSY
  } wr_state_t;
endpackage

// File: rtl/eep_bus_sampler.sv
module eep_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] pads;
  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] prev_q;

  assign pads = {sda_i, scl_i};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= '1;
      else if (s == 0) sync_q[s] <= pads;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign scl_q     = sync_q[SYNC_STAGES-1][0];
  assign sda_q     = sync_q[SYNC_STAGES-1][1];
  assign scl_rise  = scl_q & ~prev_q[0];
  assign scl_fall  = ~scl_q & prev_q[0];
  assign start_det = scl_q & prev_q[0] & prev_q[1] & ~sda_q;
  assign stop_det  = scl_q & prev_q[0] & ~prev_q[1] & sda_q;
endmodule

// File: rtl/eep_byte_rx.sv
module eep_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              listen,
  input  logic              frame_evt,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              ack_want,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             acking;

  always_ff @(posedge clk) begin
    if (rst || !listen || frame_evt) begin
      bit_cnt    <= '0;
      acking     <= 1'b0;
      sda_oe     <= 1'b0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
        rx_byte <= {rx_byte[BYTE_W-2:0], sda_q};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W-1)) byte_valid <= 1'b1;
      end
      if (scl_fall && bit_cnt == CNT_W'(BYTE_W)) begin
        if (!acking) begin
          acking <= 1'b1;
          sda_oe <= ack_want;
        end else begin
          acking  <= 1'b0;
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
        end
      end
    end
  end

  // R10: the acknowledge drive only ever starts while the bus clock is low
  assert_oe_starts_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_q);

  // R10: the drive never overlaps a data bit being shifted in
  assert_oe_not_in_data_R10: assert property (@(posedge clk) disable iff (rst)
    (scl_rise && bit_cnt < CNT_W'(BYTE_W)) |-> !sda_oe);
endmodule

// File: rtl/eep_write_ctrl.sv
module eep_write_ctrl
  import eep_pkg::*;
#(
  parameter int         PAGE_BYTES = 16,
  parameter int         TWR_CYCLES = 300,
  parameter logic [3:0] DEV_CODE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       byte_valid,
  input  logic [7:0] rx_byte,
  output logic       listen,
  output logic       ack_want,
  output logic       busy,
  output logic       mem_we,
  output logic [8:0] mem_waddr,
  output logic [7:0] mem_wdata
);
  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = 8 - PTR_W;
  localparam int TW_W  = $clog2(TWR_CYCLES + 1);

  wr_state_t          state;
  logic               a8;
  logic [PG_W-1:0]    page;
  logic [PTR_W-1:0]   ptr;
  logic [7:0]         pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic               got_data;
  logic [TW_W-1:0]    timer;
  logic [PTR_W:0]     cidx;

  assign listen = (state == ST_DEV) || (state == ST_WORD) || (state == ST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      a8       <= 1'b0;
      page     <= '0;
      ptr      <= '0;
      pmask    <= '0;
      got_data <= 1'b0;
      timer    <= '0;
      cidx     <= '0;
      busy     <= 1'b0;
      ack_want <= 1'b0;
      mem_we   <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (state == ST_BUSY) begin
        if (cidx < (PTR_W+1)'(PAGE_BYTES)) begin
          mem_we    <= pmask[cidx[PTR_W-1:0]];
          mem_waddr <= {a8, page, cidx[PTR_W-1:0]};
          mem_wdata <= pbuf[cidx[PTR_W-1:0]];
          cidx      <= cidx + 1'b1;
        end
        if (timer == '0) begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          pmask <= '0;
        end else begin
          timer <= timer - 1'b1;
        end
      end else if (start_det) begin
        state    <= ST_DEV;
        got_data <= 1'b0;
        pmask    <= '0;
        ack_want <= 1'b0;
      end else if (stop_det) begin
        ack_want <= 1'b0;
        if (state == ST_DATA && got_data) begin
          state <= ST_BUSY;
          busy  <= 1'b1;
          timer <= TW_W'(TWR_CYCLES - 1);
          cidx  <= '0;
        end else begin
          state <= ST_IDLE;
          pmask <= '0;
        end
      end else if (byte_valid) begin
        case (state)
          ST_DEV: begin
            if (rx_byte[7:4] == DEV_CODE && !rx_byte[0]) begin
              a8       <= rx_byte[1];
              ack_want <= 1'b1;
              state    <= ST_WORD;
            end else begin
              ack_want <= 1'b0;
              state    <= ST_SKIP;
            end
          end
          ST_WORD: begin
            page     <= rx_byte[7:PTR_W];
            ptr      <= rx_byte[PTR_W-1:0];
            ack_want <= 1'b1;
            state    <= ST_DATA;
          end
          ST_DATA: begin
            pbuf[ptr]  <= rx_byte;
            pmask[ptr] <= 1'b1;
            ptr        <= ptr + 1'b1;
            got_data   <= 1'b1;
            ack_want   <= 1'b1;
          end
          default: ack_want <= 1'b0;
        endcase
      end
    end
  end

  // checker counter for the busy window length
  logic [TW_W-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_busy_len_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(busy)) |-> busy_run == TW_W'(TWR_CYCLES));

  assert_busy_needs_stop_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(stop_det) && $past(got_data)));

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && state == ST_DATA && !start_det && !stop_det) |=>
      (ptr == PTR_W'($past(ptr) + 1'b1)) && $stable(page) && $stable(a8));

  assert_read_nack_R7: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && state == ST_DEV && rx_byte[0] && !start_det && !stop_det) |=> !ack_want);

  assert_deaf_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !listen);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer #(
  parameter int         PAGE_BYTES  = 16,
  parameter int         TWR_CYCLES  = 300,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       busy,
  input  logic [8:0] rd_addr,
  output logic [7:0] rd_data
);
  logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic       listen, ack_want, byte_valid;
  logic [7:0] rx_byte;
  logic       mem_we;
  logic [8:0] mem_waddr;
  logic [7:0] mem_wdata;

  eep_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_byte_rx #(.BYTE_W(8)) u_rx (
    .clk(clk), .rst(rst), .listen(listen), .frame_evt(start_det | stop_det),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ack_want(ack_want), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .sda_oe(sda_oe)
  );

  eep_write_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .TWR_CYCLES(TWR_CYCLES), .DEV_CODE(DEV_CODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .byte_valid(byte_valid), .rx_byte(rx_byte), .listen(listen),
    .ack_want(ack_want), .busy(busy), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eep_array #(.AW(9), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R4: nothing is acknowledged during the internal write
  assert_no_ack_busy_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);
endmodule

// File: tb/eep_page_writer_bench.sv
`timescale 1ns/1ps
module eep_page_writer_bench;
  localparam int TWR = 1000;
  localparam int Q   = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe, busy;
  logic [8:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_err = 0;
  int run = 0;
  int last_len = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  eep_page_writer #(.TWR_CYCLES(TWR)) u_eep_page_writer (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (busy === 1'b1) run <= run + 1;
    else begin
      if (run != 0) last_len <= run;
      run <= 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic oe_seen = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(Q);
      if (sda_oe) oe_seen = 1'b1;
      hold(Q);
      scl_m = 1'b0; hold(Q);
    end
    chk("R10 no drive in data bits", oe_seen, 1'b0);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    acked = (sda_line == 1'b0);
    hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic peek(input logic [8:0] a, output logic [7:0] d);
    rd_addr = a;
    hold(3);
    d = rd_data;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 3*TWR && busy; i++) hold(1);
    hold(2);
  endtask

  // full write transfer; acks expected on every byte
  task automatic write_xfer(input logic [7:0] dev, input logic [7:0] wa,
                            input int n, input logic [7:0] base, input string req);
    logic a;
    i2c_start;
    send_byte(dev, a); chk({req, " R2 ack slave address"}, a, 1'b1);
    send_byte(wa, a);  chk({req, " R2 ack word address"}, a, 1'b1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), a);
      chk({req, " R2 ack data"}, a, 1'b1);
    end
    i2c_stop;
    chk({req, " R3 busy after stop"}, busy, 1'b1);
    wait_idle;
    chk({req, " R9 busy length"}, last_len, TWR);
  endtask

  task automatic t_reset;
    chk("R10 reset sda_oe", sda_oe, 1'b0);
    chk("R9 reset busy", busy, 1'b0);
  endtask

  task automatic t_byte_write;
    logic [7:0] d;
    write_xfer(8'hA2, 8'hA5, 1, 8'h3C, "byte write");
    peek(9'h1A5, d); chk("R1 byte stored at upper half", d, 8'h3C);
    peek(9'h0A5, d); chk("R8 A8 selects half", d, 8'hFF);
    peek(9'h1A6, d); chk("R1 neighbour untouched", d, 8'hFF);
  endtask

  task automatic t_deaf;
    logic a;
    logic [7:0] d;
    i2c_start;
    send_byte(8'hA0, a); send_byte(8'h10, a); send_byte(8'h55, a);
    i2c_stop;
    // new transfer while the internal write runs
    i2c_start;
    send_byte(8'hA0, a); chk("R4 no ack of address while busy", a, 1'b0);
    send_byte(8'h11, a); chk("R4 no ack of word while busy", a, 1'b0);
    send_byte(8'h77, a); chk("R4 no ack of data while busy", a, 1'b0);
    i2c_stop;
    chk("R4 still busy after deaf stop", busy, 1'b1);
    wait_idle;
    chk("R9 busy length unaffected", last_len, TWR);
    hold(20);
    chk("R4 no second write", busy, 1'b0);
    peek(9'h010, d); chk("R1 committed byte", d, 8'h55);
    peek(9'h011, d); chk("R4 busy byte not stored", d, 8'hFF);
  endtask

  task automatic t_page_wrap;
    logic [7:0] d;
    write_xfer(8'hA0, 8'h3E, 5, 8'h40, "page wrap");
    peek(9'h03E, d); chk("R5 first byte", d, 8'h40);
    peek(9'h03F, d); chk("R5 page end", d, 8'h41);
    peek(9'h030, d); chk("R5 wrapped to page start", d, 8'h42);
    peek(9'h032, d); chk("R5 wrapped third", d, 8'h44);
    peek(9'h040, d); chk("R5 next page untouched", d, 8'hFF);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    write_xfer(8'hA0, 8'h60, 18, 8'h80, "overflow");
    peek(9'h060, d); chk("R6 slot 0 overwritten", d, 8'h90);
    peek(9'h061, d); chk("R6 slot 1 overwritten", d, 8'h91);
    peek(9'h062, d); chk("R6 slot 2 kept", d, 8'h82);
    peek(9'h06F, d); chk("R6 slot 15 kept", d, 8'h8F);
    peek(9'h070, d); chk("R6 next page untouched", d, 8'hFF);
  endtask

  task automatic t_read_bit;
    logic a;
    logic [7:0] d;
    i2c_start;
    send_byte(8'hA1, a); chk("R7 read request not acked", a, 1'b0);
    send_byte(8'h20, a); chk("R7 silent until START", a, 1'b0);
    send_byte(8'h66, a); chk("R7 silent on data", a, 1'b0);
    i2c_stop; hold(10);
    chk("R7 no write after read request", busy, 1'b0);
    peek(9'h020, d); chk("R7 array unchanged", d, 8'hFF);
  endtask

  task automatic t_wrong_code;
    logic a;
    i2c_start;
    send_byte(8'hB0, a); chk("R8 wrong code not acked", a, 1'b0);
    send_byte(8'h20, a); chk("R8 silent until START", a, 1'b0);
    i2c_stop; hold(10);
    chk("R8 no write", busy, 1'b0);
    // don't-care bits 3:2 set, code correct
    write_xfer(8'hAC, 8'h24, 1, 8'h5A, "dont care bits");
    begin
      logic [7:0] d;
      peek(9'h024, d); chk("R8 bits 3:2 ignored", d, 8'h5A);
    end
  endtask

  task automatic t_abandon;
    logic a;
    logic [7:0] d;
    i2c_start;
    send_byte(8'hA0, a); send_byte(8'h50, a);
    i2c_stop; hold(10);
    chk("R3 stop without data starts nothing", busy, 1'b0);
    i2c_start;
    send_byte(8'hA0, a); send_byte(8'h51, a);
    // repeated START before any data byte
    write_xfer(8'hA0, 8'h52, 1, 8'h99, "after restart");
    peek(9'h051, d); chk("R3 abandoned transfer left array", d, 8'hFF);
    peek(9'h052, d); chk("R3 restarted write stored", d, 8'h99);
  endtask

  initial begin
    hold(5);
    rst = 1'b0;
    hold(5);
    t_reset;
    t_byte_write;
    t_deaf;
    t_page_wrap;
    t_overflow;
    t_read_bit;
    t_wrong_code;
    t_abandon;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule